// File: doc/BRIEF.md
# Per-Hart Interrupt Delivery Controller

This block handles wire-style interrupt delivery for a small set of harts. Each cycle, for every hart, it looks at the sources that are enabled and pending, aimed at that hart, and below that hart's threshold. It keeps the most urgent one as the hart's top interrupt and drives one interrupt line per hart.

Software reaches the block through a simple word-wide register port. That port gives access to the per-source target entries and to a 32-byte window per hart. The window holds the delivery enable, the force bit, the threshold, the top-interrupt value and the claim register.

Reading the claim register hands the current winner to software. It also emits a one-cycle command that tells the upstream pending logic to clear that source. The command re-pends the source when its level input is still active. Edge and level detection of the raw sources, and message delivery, live outside this block.

Top module: `hart_irq_deliver`

## Requirements
- R1: After reset every hart line is low, top values read 0, delivery enable, force and threshold read 0, and every target entry reads hart 0, priority 1.
- R2: Among qualifying sources, the smallest priority number wins, and on equal priority the smaller source number wins.
- R3: A source qualifies only if its enabled-and-pending bit is set and its target hart field equals the hart's index. Source 0 never qualifies.
- R4: A nonzero threshold excludes sources whose priority is greater than or equal to it, and a zero threshold excludes nothing. A written threshold keeps only the implemented priority bits.
- R5: The top value carries the source number in bits 25:16 and the priority in bits 7:0, and is 0 when nothing qualifies. It follows input changes one clock later.
- R6: A hart line is high exactly when the domain enable input, the hart's delivery enable and either its force bit or a nonzero top value are all true.
- R7: A claim read returns the top value and, one cycle after the access starts, raises `pendClr` for one cycle with that source on `pendSrc`.
- R8: A claim raises `pendSet` together with `pendClr` when the claimed source's mode is 2'b10 (level high) with its input at 1, or mode 2'b11 (level low) with its input at 0. Other modes never re-pend.
- R9: A claim read with nothing qualifying returns 0, issues no command and clears that hart's force bit.
- R10: A read held for several cycles at one address is a single access: one capture of read data and at most one claim command.
- R11: A target write keeps the low priority bits (parameter `PRIO_BITS`) of data bits 7:0 and stores a result of 0 as 1. It takes the hart index from data bits 31:18, and reads back in the same layout.
- R12: Target entry s sits at byte 0x3000+4*s for s from 1 up, and hart h's window at 0x4000+32*h. Within a window: delivery 0x00, force 0x04, threshold 0x08, top 0x18, claim 0x1C. Other offsets and unaligned addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| domainEn | input | 1 | Domain-wide interrupt enable |
| srcEnPend | input | NUM_SRC | Per-source enabled-and-pending flags |
| srcMode | input | 2*NUM_SRC | Per-source sense mode, two bits each |
| srcLevel | input | NUM_SRC | Per-source current input level |
| regRd | input | 1 | Register read request, may be held |
| regWr | input | 1 | Register write request |
| regAddr | input | 16 | Byte address |
| regWdata | input | 32 | Write data |
| rdData | output | 32 | Read data, valid from the cycle after the access starts |
| hartIrq | output | NUM_HART | Per-hart interrupt line |
| pendClr | output | 1 | Clear-pending command for `pendSrc` |
| pendSet | output | 1 | Re-pend command, only together with `pendClr` |
| pendSrc | output | $clog2(NUM_SRC) | Source addressed by the command |

## Verification
A claim read and the arrival of a new, more urgent pending source can land in the same clock. The bench raises a priority-1 source in the very cycle a claim of a priority-3 winner starts. It then expects the claim to return and clear only the old winner, and the top value to show the newcomer afterwards. Level re-pend and the force clear on an empty claim are each judged both on the command outputs and on the hart line.

// File: rtl/hid_pkg.sv
package hid_pkg;
  localparam int IDX_W  = 10;
  localparam int HSEL_W = 14;
  localparam int TGT_HART_LSB = 18;
  localparam int TOP_SRC_LSB  = 16;

  localparam logic [15:0] TGT_BASE  = 16'h3000;
  localparam logic [15:0] HART_BASE = 16'h4000;

  localparam logic [4:0] OFF_DELIV = 5'h00;
  localparam logic [4:0] OFF_FORCE = 5'h04;
  localparam logic [4:0] OFF_THR   = 5'h08;
  localparam logic [4:0] OFF_TOP   = 5'h18;
  localparam logic [4:0] OFF_CLAIM = 5'h1C;

  localparam logic [1:0] MODE_LVL_HIGH = 2'b10;
  localparam logic [1:0] MODE_LVL_LOW  = 2'b11;

  typedef enum logic [2:0] {
    RD_NONE, RD_TGT, RD_DELIV, RD_FORCE, RD_THR, RD_TOP, RD_CLAIM
  } rdkind_e;

  typedef struct packed {
    logic              tgtWr;
    logic              delivWr;
    logic              forceWr;
    logic              thrWr;
    logic              rdCapture;
    rdkind_e           rdKind;
    logic [IDX_W-1:0]  srcIdx;
    logic [HSEL_W-1:0] hartIdx;
    logic [31:0]       wdata;
  } strobe_t;
endpackage

// File: rtl/hid_select_tree.sv
module hid_select_tree #(
  parameter int NUM_SRC   = 32,
  parameter int PRIO_BITS = 3
) (
  input  logic [NUM_SRC-1:0]           cand,
  input  logic [NUM_SRC*PRIO_BITS-1:0] prioFlat,
  output logic                         bestValid,
  output logic [$clog2(NUM_SRC)-1:0]   bestSrc,
  output logic [PRIO_BITS-1:0]         bestPrio
);
  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int LEAVES = 1 << SRC_W;

  typedef struct packed {
    logic                 v;
    logic [SRC_W-1:0]     id;
    logic [PRIO_BITS-1:0] pr;
  } node_t;

  node_t nodes [1:2*LEAVES-1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_SRC) begin : g_real
      assign nodes[LEAVES+i] = {cand[i], SRC_W'(i), prioFlat[i*PRIO_BITS +: PRIO_BITS]};
    end else begin : g_pad
      assign nodes[LEAVES+i] = '0;
    end
  end

  // Left subtree always holds the lower source numbers, so ties go left.
  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    logic takeLeft;
    assign takeLeft = nodes[2*n].v && (!nodes[2*n+1].v || nodes[2*n].pr <= nodes[2*n+1].pr);
    assign nodes[n] = takeLeft ? nodes[2*n] : nodes[2*n+1];
  end

  assign bestValid = nodes[1].v;
  assign bestSrc   = nodes[1].id;
  assign bestPrio  = nodes[1].pr;
endmodule

// File: rtl/hid_ctrl.sv
module hid_ctrl
  import hid_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_HART = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regRd,
  input  logic        regWr,
  input  logic [15:0] regAddr,
  input  logic [31:0] regWdata,
  output strobe_t     strb
);
  localparam logic [16:0] TGT_END  = 17'(32'h3000 + 4 * NUM_SRC);
  localparam logic [16:0] HART_END = 17'(32'h4000 + 32 * NUM_HART);

  logic        rdPrev;
  logic [15:0] addrPrev;
  logic        rdFirst;
  logic        aligned, inTgt, inHart;
  logic [15:0] tgtOff, hartOff;
  logic [4:0]  winOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev   <= 1'b0;
      addrPrev <= '0;
    end else begin
      rdPrev   <= regRd;
      addrPrev <= regAddr;
    end
  end

  // A read access is a run of read cycles at one address; act on its first cycle only.
  assign rdFirst = regRd && !(rdPrev && (addrPrev == regAddr));

  always_comb begin
    tgtOff  = regAddr - TGT_BASE;
    hartOff = regAddr - HART_BASE;
    aligned = (regAddr[1:0] == 2'b00);
    inTgt   = aligned && (regAddr >= TGT_BASE) && ({1'b0, regAddr} < TGT_END)
              && (tgtOff[15:2] != '0);
    inHart  = aligned && (regAddr >= HART_BASE) && ({1'b0, regAddr} < HART_END);
    winOff  = hartOff[4:0];
  end

  always_comb begin
    strb         = '0;
    strb.rdKind  = RD_NONE;
    strb.srcIdx  = tgtOff[2 +: IDX_W];
    strb.hartIdx = HSEL_W'(hartOff[15:5]);
    strb.wdata   = regWdata;
    if (regRd) begin
      strb.rdCapture = rdFirst;
      if (inTgt) begin
        strb.rdKind = RD_TGT;
      end else if (inHart) begin
        case (winOff)
          OFF_DELIV: strb.rdKind = RD_DELIV;
          OFF_FORCE: strb.rdKind = RD_FORCE;
          OFF_THR:   strb.rdKind = RD_THR;
          OFF_TOP:   strb.rdKind = RD_TOP;
          OFF_CLAIM: strb.rdKind = RD_CLAIM;
          default:   strb.rdKind = RD_NONE;
        endcase
      end
    end else if (regWr) begin
      strb.tgtWr   = inTgt;
      strb.delivWr = inHart && (winOff == OFF_DELIV);
      strb.forceWr = inHart && (winOff == OFF_FORCE);
      strb.thrWr   = inHart && (winOff == OFF_THR);
    end
  end
endmodule

// File: rtl/hid_datapath.sv
module hid_datapath
  import hid_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_HART  = 2,
  parameter int PRIO_BITS = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       domainEn,
  input  logic [NUM_SRC-1:0]         srcEnPend,
  input  logic [2*NUM_SRC-1:0]       srcMode,
  input  logic [NUM_SRC-1:0]         srcLevel,
  input  strobe_t                    strb,
  output logic [NUM_HART-1:0]        hartIrq,
  output logic                       pendClr,
  output logic                       pendSet,
  output logic [$clog2(NUM_SRC)-1:0] pendSrc,
  output logic [31:0]                rdData
);
  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int HART_W = (NUM_HART > 1) ? $clog2(NUM_HART) : 1;

  logic [PRIO_BITS-1:0] tgtPrio [NUM_SRC];
  logic [HSEL_W-1:0]    tgtHart [NUM_SRC];
  logic                 deliver [NUM_HART];
  logic                 force_q [NUM_HART];
  logic [PRIO_BITS-1:0] thr     [NUM_HART];
  logic                 topValid[NUM_HART];
  logic [SRC_W-1:0]     topSrc  [NUM_HART];
  logic [PRIO_BITS-1:0] topPrio [NUM_HART];

  logic [NUM_SRC*PRIO_BITS-1:0] prioFlat;
  logic [SRC_W-1:0]     srcSel;
  logic [HART_W-1:0]    hSel;
  logic [PRIO_BITS-1:0] wPrio, wPrioFixed;
  logic [HSEL_W-1:0]    wHart;
  logic                 claimNow;
  logic                 selValid;
  logic [SRC_W-1:0]     selSrc;
  logic [1:0]           selMode;
  logic                 selLvlActive;
  logic [31:0]          rdNext;
  logic                 unusedOk;

  assign srcSel     = strb.srcIdx[SRC_W-1:0];
  assign hSel       = strb.hartIdx[HART_W-1:0];
  assign wPrio      = strb.wdata[PRIO_BITS-1:0];
  assign wPrioFixed = (wPrio == '0) ? PRIO_BITS'(1) : wPrio;
  assign wHart      = strb.wdata[TGT_HART_LSB +: HSEL_W];
  assign claimNow   = strb.rdCapture && (strb.rdKind == RD_CLAIM);
  assign unusedOk   = ^{strb.srcIdx, strb.hartIdx, strb.wdata};

  // Target table
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_tgt
    assign prioFlat[s*PRIO_BITS +: PRIO_BITS] = tgtPrio[s];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tgtPrio[s] <= PRIO_BITS'(1);
        tgtHart[s] <= '0;
      end else if (strb.tgtWr && (srcSel == SRC_W'(s))) begin
        tgtPrio[s] <= wPrioFixed;
        tgtHart[s] <= wHart;
      end
    end
  end

  // Per-hart selection, registers and line
  for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
    logic [NUM_SRC-1:0]   cand;
    logic                 bestValid;
    logic [SRC_W-1:0]     bestSrc;
    logic [PRIO_BITS-1:0] bestPrio;
    logic                 hartHit;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cand
      if (s == 0) begin : g_zero
        assign cand[s] = 1'b0;
      end else begin : g_src
        assign cand[s] = srcEnPend[s] && (tgtHart[s] == HSEL_W'(h))
                         && ((thr[h] == '0) || (tgtPrio[s] < thr[h]));
      end
    end

    hid_select_tree #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS)) u_tree (
      .cand     (cand),
      .prioFlat (prioFlat),
      .bestValid(bestValid),
      .bestSrc  (bestSrc),
      .bestPrio (bestPrio)
    );

    assign hartHit = (hSel == HART_W'(h));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        topValid[h] <= 1'b0;
        topSrc[h]   <= '0;
        topPrio[h]  <= '0;
        deliver[h]  <= 1'b0;
        force_q[h]  <= 1'b0;
        thr[h]      <= '0;
      end else begin
        topValid[h] <= bestValid;
        topSrc[h]   <= bestValid ? bestSrc : '0;
        topPrio[h]  <= bestValid ? bestPrio : '0;
        if (strb.delivWr && hartHit) deliver[h] <= strb.wdata[0];
        if (strb.thrWr && hartHit)   thr[h]     <= strb.wdata[PRIO_BITS-1:0];
        if (claimNow && hartHit && !topValid[h]) begin
          force_q[h] <= 1'b0;
        end else if (strb.forceWr && hartHit) begin
          force_q[h] <= strb.wdata[0];
        end
      end
    end

    assign hartIrq[h] = domainEn && deliver[h] && (force_q[h] || topValid[h]);
  end

  // Claim command
  assign selValid     = topValid[hSel];
  assign selSrc       = topSrc[hSel];
  assign selMode      = srcMode[{selSrc, 1'b0} +: 2];
  assign selLvlActive = ((selMode == MODE_LVL_HIGH) && srcLevel[selSrc])
                     || ((selMode == MODE_LVL_LOW) && !srcLevel[selSrc]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendClr <= 1'b0;
      pendSet <= 1'b0;
      pendSrc <= '0;
    end else begin
      pendClr <= claimNow && selValid;
      pendSet <= claimNow && selValid && selLvlActive;
      if (claimNow && selValid) pendSrc <= selSrc;
    end
  end

  // Read data
  always_comb begin
    case (strb.rdKind)
      RD_TGT:   rdNext = (32'(tgtHart[srcSel]) << TGT_HART_LSB) | 32'(tgtPrio[srcSel]);
      RD_DELIV: rdNext = 32'(deliver[hSel]);
      RD_FORCE: rdNext = 32'(force_q[hSel]);
      RD_THR:   rdNext = 32'(thr[hSel]);
      RD_TOP, RD_CLAIM:
                rdNext = (32'(topSrc[hSel]) << TOP_SRC_LSB) | 32'(topPrio[hSel]);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdData <= '0;
    else if (strb.rdCapture) rdData <= rdNext;
  end
endmodule

// File: rtl/hart_irq_deliver.sv
module hart_irq_deliver
  import hid_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_HART  = 2,
  parameter int PRIO_BITS = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       domainEn,
  input  logic [NUM_SRC-1:0]         srcEnPend,
  input  logic [2*NUM_SRC-1:0]       srcMode,
  input  logic [NUM_SRC-1:0]         srcLevel,
  input  logic                       regRd,
  input  logic                       regWr,
  input  logic [15:0]                regAddr,
  input  logic [31:0]                regWdata,
  output logic [31:0]                rdData,
  output logic [NUM_HART-1:0]        hartIrq,
  output logic                       pendClr,
  output logic                       pendSet,
  output logic [$clog2(NUM_SRC)-1:0] pendSrc
);
  strobe_t strb;

  hid_ctrl #(.NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regRd   (regRd),
    .regWr   (regWr),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .strb    (strb)
  );

  hid_datapath #(.NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .PRIO_BITS(PRIO_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .domainEn (domainEn),
    .srcEnPend(srcEnPend),
    .srcMode  (srcMode),
    .srcLevel (srcLevel),
    .strb     (strb),
    .hartIrq  (hartIrq),
    .pendClr  (pendClr),
    .pendSet  (pendSet),
    .pendSrc  (pendSrc),
    .rdData   (rdData)
  );
endmodule

// File: rtl/hid_checker.sv
module hid_checker #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_HART = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       domainEn,
  input logic                       regRd,
  input logic [15:0]                regAddr,
  input logic [NUM_HART-1:0]        hartIrq,
  input logic                       pendClr,
  input logic                       pendSet,
  input logic [$clog2(NUM_SRC)-1:0] pendSrc
);
  p_line_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    !domainEn |-> (hartIrq == '0));

  p_repend_with_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    pendSet |-> pendClr);

  p_cmd_src_nonzero_r7: assert property (@(posedge clk) disable iff (!rstN)
    pendClr |-> (pendSrc != '0));

  p_cmd_follows_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    pendClr |-> $past(regRd));

  p_held_read_once_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && $past(regRd) && $stable(regAddr)) |=> !pendClr);
endmodule

bind hart_irq_deliver hid_checker #(.NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .domainEn(domainEn),
  .regRd   (regRd),
  .regAddr (regAddr),
  .hartIrq (hartIrq),
  .pendClr (pendClr),
  .pendSet (pendSet),
  .pendSrc (pendSrc)
);

// File: tb/tb_hart_irq_deliver.sv
module tb_hart_irq_deliver;
  localparam int NUM_SRC = 32;
  localparam int NUM_HART = 2;
  localparam int PB = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic domainEn = 1'b1;
  logic [NUM_SRC-1:0] enPend = '0;
  logic [2*NUM_SRC-1:0] srcMode = '0;
  logic [NUM_SRC-1:0] srcLevel = '0;
  logic regRd = 1'b0, regWr = 1'b0;
  logic [15:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdData;
  logic [NUM_HART-1:0] hartIrq;
  logic pendClr, pendSet;
  logic [4:0] pendSrc;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hart_irq_deliver #(.NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .PRIO_BITS(PB)) dut (
    .clk(clk), .rstN(rstN), .domainEn(domainEn), .srcEnPend(enPend),
    .srcMode(srcMode), .srcLevel(srcLevel), .regRd(regRd), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .rdData(rdData), .hartIrq(hartIrq),
    .pendClr(pendClr), .pendSet(pendSet), .pendSrc(pendSrc)
  );

  function automatic logic [15:0] tgtAddr(input int s);
    return 16'(32'h3000 + 4 * s);
  endfunction
  function automatic logic [15:0] winAddr(input int h, input int off);
    return 16'(32'h4000 + 32 * h + off);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, input int hold, input logic [NUM_SRC-1:0] orMask,
                         output logic [31:0] d, output int clr, output logic setSeen,
                         output logic [4:0] srcSeen, output logic heldOk);
    clr = 0; setSeen = 1'b0; srcSeen = '0; d = '0; heldOk = 1'b1;
    @(negedge clk);
    regRd = 1'b1; regAddr = a; enPend = enPend | orMask;
    for (int i = 0; i < hold; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (pendClr) begin clr++; setSeen = pendSet; srcSeen = pendSrc; end
      if (i == 0) d = rdData;
      else if (rdData !== d) heldOk = 1'b0;
    end
    regRd = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    int c; logic s; logic [4:0] x; logic ok;
    busRead(a, 1, '0, d, c, s, x, ok);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 lines low", 32'(hartIrq), 0);
    rd(winAddr(0, 'h18), d); chk("R1 top h0", d, 0);
    rd(tgtAddr(5), d);       chk("R1 target prio", d, 1);
    rd(winAddr(1, 'h00), d); chk("R1 deliver h1", d, 0);
    rd(winAddr(1, 'h08), d); chk("R1 threshold h1", d, 0);
  endtask

  task automatic t_target();
    logic [31:0] d;
    busWrite(tgtAddr(3), 32'(1) << 18); rd(tgtAddr(3), d);
    chk("R11 zero prio stored as one", d, (32'(1) << 18) | 1);
    busWrite(tgtAddr(3), 32'h0D); rd(tgtAddr(3), d);
    chk("R11 prio masked", d, 5);
    busWrite(tgtAddr(3), 32'h08); rd(tgtAddr(3), d);
    chk("R11 masked to zero becomes one", d, 1);
  endtask

  task automatic t_select();
    logic [31:0] d;
    busWrite(tgtAddr(2), 3);
    busWrite(tgtAddr(5), 1);
    busWrite(tgtAddr(7), 1);
    busWrite(tgtAddr(4), (32'(1) << 18) | 2);
    @(negedge clk); enPend = (1 << 2) | (1 << 4) | (1 << 5) | (1 << 7);
    settle();
    rd(winAddr(0, 'h18), d); chk("R2 tie lower source wins", d, 32'h0005_0001);
    rd(winAddr(1, 'h18), d); chk("R5 top format hart1", d, 32'h0004_0002);
    @(negedge clk); enPend[5] = 1'b0; settle();
    rd(winAddr(0, 'h18), d); chk("R2 next lowest prio", d, 32'h0007_0001);
    @(negedge clk); enPend = 1; settle();
    rd(winAddr(0, 'h18), d); chk("R3 source zero ignored", d, 0);
    @(negedge clk); enPend = 1 << 4; settle();
    rd(winAddr(0, 'h18), d); chk("R3 other hart target ignored", d, 0);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    @(negedge clk); enPend = (1 << 2) | (1 << 7); settle();
    busWrite(winAddr(0, 'h08), 3); settle();
    rd(winAddr(0, 'h18), d); chk("R4 thr3 keeps prio1", d, 32'h0007_0001);
    busWrite(winAddr(0, 'h08), 1); settle();
    rd(winAddr(0, 'h18), d); chk("R4 thr1 excludes all", d, 0);
    busWrite(winAddr(0, 'h08), 9); settle();
    rd(winAddr(0, 'h08), d); chk("R4 thr masked", d, 1);
    @(negedge clk); enPend = 1 << 2;
    busWrite(winAddr(0, 'h08), 3); settle();
    rd(winAddr(0, 'h18), d); chk("R4 equal prio excluded", d, 0);
    busWrite(winAddr(0, 'h08), 0); settle();
    rd(winAddr(0, 'h18), d); chk("R4 zero thr excludes none", d, 32'h0002_0003);
    @(negedge clk); enPend = (1 << 2) | (1 << 7); settle();
  endtask

  task automatic t_line();
    chk("R6 no deliver", 32'(hartIrq[0]), 0);
    busWrite(winAddr(0, 'h00), 1); settle();
    chk("R6 line up", 32'(hartIrq[0]), 1);
    @(negedge clk); domainEn = 1'b0; settle();
    chk("R6 domain off", 32'(hartIrq[0]), 0);
    @(negedge clk); domainEn = 1'b1;
    busWrite(winAddr(1, 'h00), 1); settle();
    chk("R6 hart1 idle", 32'(hartIrq[1]), 0);
    busWrite(winAddr(1, 'h04), 1); settle();
    chk("R6 force raises", 32'(hartIrq[1]), 1);
  endtask

  task automatic t_claim_empty();
    logic [31:0] d; int c; logic s; logic [4:0] x; logic ok;
    busRead(winAddr(1, 'h1C), 1, '0, d, c, s, x, ok);
    chk("R9 empty claim data", d, 0);
    chk("R9 no command", 32'(c), 0);
    rd(winAddr(1, 'h04), d); chk("R9 force cleared", d, 0);
    settle();
    chk("R9 line drops", 32'(hartIrq[1]), 0);
  endtask

  task automatic t_claim();
    logic [31:0] d; int c; logic s; logic [4:0] x; logic ok;
    busRead(winAddr(0, 'h1C), 1, '0, d, c, s, x, ok);
    chk("R7 claim data", d, 32'h0007_0001);
    chk("R7 one clear", 32'(c), 1);
    chk("R7 clear source", 32'(x), 7);
    chk("R8 edge no repend", 32'(s), 0);
    @(negedge clk); enPend[7] = 1'b0;
    srcMode[2*2 +: 2] = 2'b10; srcLevel[2] = 1'b1; settle();
    busRead(winAddr(0, 'h1C), 1, '0, d, c, s, x, ok);
    chk("R7 claim src2", d, 32'h0002_0003);
    chk("R8 level high active repends", 32'(s), 1);
    settle();
    @(negedge clk); srcMode[2*2 +: 2] = 2'b11; srcLevel[2] = 1'b0;
    busRead(winAddr(0, 'h1C), 1, '0, d, c, s, x, ok);
    chk("R8 level low active repends", 32'(s), 1);
    settle();
    @(negedge clk); srcLevel[2] = 1'b1;
    busRead(winAddr(0, 'h1C), 1, '0, d, c, s, x, ok);
    chk("R8 level low inactive", 32'(s), 0);
    chk("R8 still cleared", 32'(c), 1);
    @(negedge clk); enPend[2] = 1'b0; settle();
    chk("R6 line after claims", 32'(hartIrq[0]), 0);
  endtask

  task automatic t_claim_held();
    logic [31:0] d; int c; logic s; logic [4:0] x; logic ok;
    @(negedge clk); enPend[5] = 1'b1; settle();
    busRead(winAddr(0, 'h1C), 4, '0, d, c, s, x, ok);
    chk("R10 held claim data", d, 32'h0005_0001);
    chk("R10 single command", 32'(c), 1);
    chk("R10 data held", 32'(ok), 1);
    @(negedge clk); enPend[5] = 1'b0; settle();
  endtask

  task automatic t_claim_race();
    logic [31:0] d; int c; logic s; logic [4:0] x; logic ok;
    @(negedge clk); enPend = 1 << 2; settle();
    busRead(winAddr(0, 'h1C), 1, 32'(1) << 5, d, c, s, x, ok);
    chk("R7 race claims old winner", d, 32'h0002_0003);
    chk("R7 race clears old source", 32'(x), 2);
    @(negedge clk); enPend[2] = 1'b0; settle();
    rd(winAddr(0, 'h18), d); chk("R5 newcomer kept", d, 32'h0005_0001);
  endtask

  task automatic t_window();
    logic [31:0] d;
    rd(winAddr(0, 'h0C), d); chk("R12 unused offset reads 0", d, 0);
    busWrite(winAddr(0, 'h0C), 0);
    busWrite(winAddr(0, 'h01), 0);
    rd(winAddr(0, 'h00), d); chk("R12 deliver unchanged", d, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_target();
    t_select();
    t_threshold();
    t_line();
    t_claim_empty();
    t_claim();
    t_claim_held();
    t_claim_race();
    t_window();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule